// File: doc/BRIEF.md
# Bit-Serial Single-Precision Divider

This block divides one 32-bit single-precision floating-point value by another and produces one quotient bit on each clock. The sign is computed on its own. The quotient exponent is the dividend exponent minus the divisor exponent, with the bias added back in. The two 24-bit significands, each with its hidden leading one restored, are divided as plain integers by restoring shift-and-subtract. The loop runs two bits past the 24 that are kept. The first of these extra bits makes room for a one-place normalising shift. The next one decides the rounding: when it is one the kept significand is incremented, and otherwise the result is truncated.

A caller pulses `start` with both operands valid while `busy` is low. The block captures the operands, runs for a fixed number of cycles and then raises `done` for one cycle. At that point `result` and `div_by_zero` are valid, and they hold until the next `done`. Operands with a zero exponent field are treated as zero. Denormals, NaN inputs, exponent overflow or underflow of the quotient, and ties-to-even rounding are not handled.

The controller walks four states. IDLE goes to SETUP when start is seen. SETUP goes to DIVIDE after one cycle, loading the remainder and divisor. DIVIDE stays for 26 cycles and then goes to NORMAL. NORMAL goes to IDLE after one cycle, registering the packed result and pulsing done.

Top module: `fpdiv_serial`

## Requirements
- R1: The sign bit (bit 31) of every result is the XOR of the operand sign bits, including zero and infinity results.
- R2: For nonzero operands the result exponent field (bits 30:23) equals expA - expB + 127. It is one less than that when the dividend significand is smaller than the divisor significand.
- R3: For nonzero operands the fraction field (bits 22:0) is the quotient significand truncated to 24 bits, plus one when the next quotient bit is one (for example 1.0/3.0 gives 0x3EAAAAAB and 5.0/3.0 gives 0x3FD55555).
- R4: A dividend with exponent field 0 and a nonzero divisor gives a signed zero (bits 30:0 all zero) with div_by_zero low.
- R5: A divisor with exponent field 0 gives a signed infinity (exponent field all ones, fraction zero) with div_by_zero high. This applies even when the dividend is also zero.
- R6: A start seen while busy is low is accepted on that clock edge. busy is high from the next cycle until done rises. done is high for exactly one cycle, beginning 28 clock edges after the accepting edge, and busy is low whenever done is high.
- R7: A start pulse while busy is high has no effect. The running division finishes at its original time with its original operands.
- R8: While reset is asserted and right after it is released, busy, done, div_by_zero and result are all zero.
- R9: result and div_by_zero change only at the edge that raises done and stay stable between done pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division with the current operands |
| op_a | input | 32 | Dividend, single-precision |
| op_b | input | 32 | Divisor, single-precision |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse marking a new valid result |
| result | output | 32 | Quotient, single-precision |
| div_by_zero | output | 1 | The last result came from a zero divisor |

## Verification
The case hardest to reach from the ports is the rounding decision. It depends on the single quotient bit just below the kept precision, and that bit only shows through the last place of the fraction. The stimulus therefore uses quotients with repeating binary expansions whose 25th significant bit is known by hand. Values such as one third, one seventh and one fifth round up. Five thirds truncates. These cases are mixed with quotients below one, which take the normalising shift. A second hard case is a start pulse arriving in the middle of a division. The bench injects one with different operands partway through the run and checks that both the result and the completion time belong to the first request.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_DIVIDE,
        ST_NORMAL
    } fpdiv_state_t;

endpackage

// File: rtl/fpdiv_unpack.sv
module fpdiv_unpack #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int SIG_W  = FRAC_W + 1
) (
    input  logic [WORD_W-1:0] word,
    output logic              sign,
    output logic [EXP_W-1:0]  expo,
    output logic [SIG_W-1:0]  sig,
    output logic              is_zero
);

    always_comb begin
        sign    = word[WORD_W-1];
        expo    = word[WORD_W-2:FRAC_W];
        sig     = {1'b1, word[FRAC_W-1:0]};
        is_zero = (expo == '0);
    end

endmodule

// File: rtl/fpdiv_iter.sv
module fpdiv_iter #(
    parameter int SIG_W = 24,
    parameter int QUO_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [SIG_W-1:0] num,
    input  logic [SIG_W-1:0] den,
    output logic [QUO_W-1:0] quo
);

    // remainder stays below twice the divisor, so one spare bit suffices
    logic [SIG_W:0]   rem;
    logic [SIG_W-1:0] div_q;
    logic [SIG_W-1:0] diff;
    logic             fits;

    always_comb begin
        fits = (rem >= {1'b0, div_q});
        diff = rem[SIG_W-1:0] - div_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            div_q <= '0;
            quo   <= '0;
        end else if (load) begin
            rem   <= {1'b0, num};
            div_q <= den;
            quo   <= '0;
        end else if (step) begin
            quo <= {quo[QUO_W-2:0], fits};
            rem <= fits ? {diff, 1'b0} : {rem[SIG_W-1:0], 1'b0};
        end
    end

endmodule

// File: rtl/fpdiv_round.sv
module fpdiv_round #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W,
    localparam int QUO_W  = FRAC_W + 3,
    localparam int BIAS   = (1 << (EXP_W - 1)) - 1
) (
    input  logic [QUO_W-1:0]  quo,
    input  logic [EXP_W-1:0]  exp_a,
    input  logic [EXP_W-1:0]  exp_b,
    input  logic              sign,
    input  logic              zero_a,
    input  logic              zero_b,
    output logic [WORD_W-1:0] word
);

    logic              ge_one;
    logic [FRAC_W-1:0] kept;
    logic              rbit;
    logic [FRAC_W-1:0] frac;
    logic [EXP_W-1:0]  expo;

    always_comb begin
        ge_one = quo[QUO_W-1];
        kept   = ge_one ? quo[QUO_W-2:2] : quo[QUO_W-3:1];
        rbit   = ge_one ? quo[1] : quo[0];
        frac   = kept + FRAC_W'(rbit);
        expo   = exp_a - exp_b + EXP_W'(BIAS) - EXP_W'(!ge_one);
        if (zero_b)
            word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (zero_a)
            word = {sign, {(WORD_W-1){1'b0}}};
        else
            word = {sign, expo, frac};
    end

endmodule

// File: rtl/fpdiv_serial.sv
module fpdiv_serial
    import fpdiv_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] result,
    output logic              div_by_zero
);

    localparam int SIG_W = FRAC_W + 1;
    localparam int QUO_W = SIG_W + 2;
    localparam int CNT_W = $clog2(QUO_W);

    fpdiv_state_t state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] a_q, b_q;

    logic              sgn_a, sgn_b, zero_a, zero_b;
    logic [EXP_W-1:0]  exp_a, exp_b;
    logic [SIG_W-1:0]  sig_a, sig_b;
    logic [QUO_W-1:0]  quo;
    logic [WORD_W-1:0] packed_w;
    logic              last_bit;

    fpdiv_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
        .word(a_q), .sign(sgn_a), .expo(exp_a), .sig(sig_a), .is_zero(zero_a)
    );

    fpdiv_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
        .word(b_q), .sign(sgn_b), .expo(exp_b), .sig(sig_b), .is_zero(zero_b)
    );

    fpdiv_iter #(.SIG_W(SIG_W), .QUO_W(QUO_W)) u_iter (
        .clk  (clk),
        .rst_n(rst_n),
        .load (state == ST_SETUP),
        .step (state == ST_DIVIDE),
        .num  (sig_a),
        .den  (sig_b),
        .quo  (quo)
    );

    fpdiv_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_round (
        .quo   (quo),
        .exp_a (exp_a),
        .exp_b (exp_b),
        .sign  (sgn_a ^ sgn_b),
        .zero_a(zero_a),
        .zero_b(zero_b),
        .word  (packed_w)
    );

    assign last_bit = (cnt == CNT_W'(QUO_W - 1));
    assign busy     = (state != ST_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start)    state_nx = ST_SETUP;
            ST_SETUP:                state_nx = ST_DIVIDE;
            ST_DIVIDE: if (last_bit) state_nx = ST_NORMAL;
            ST_NORMAL:               state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // state register, iteration counter and operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            a_q   <= '0;
            b_q   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                a_q <= op_a;
                b_q <= op_b;
            end
            if (state == ST_DIVIDE)
                cnt <= cnt + 1'b1;
            else
                cnt <= '0;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done        <= 1'b0;
            result      <= '0;
            div_by_zero <= 1'b0;
        end else begin
            done <= (state == ST_NORMAL);
            if (state == ST_NORMAL) begin
                result      <= packed_w;
                div_by_zero <= zero_b;
            end
        end
    end

endmodule

// File: rtl/fpdiv_serial_chk.sv
module fpdiv_serial_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [WORD_W-1:0] result,
    input logic              div_by_zero
);

    localparam int LAT   = FRAC_W + 5;
    localparam int LCN_W = $clog2(LAT + 2) + 1;

    logic [LCN_W-1:0] since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since <= '0;
        else if (start && !busy)
            since <= '0;
        else if (busy)
            since <= since + 1'b1;
    end

    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_not_busy_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r6_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since == LCN_W'(LAT)));

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_by_zero) |-> done);

    a_r5_inf_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        div_by_zero |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

endmodule

bind fpdiv_serial fpdiv_serial_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .div_by_zero(div_by_zero)
);

// File: tb/fpdiv_serial_test.sv
`timescale 1ns/1ps
module fpdiv_serial_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        busy, done, div_by_zero;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;
    int lat;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fpdiv_serial uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
        .busy(busy), .done(done), .result(result), .div_by_zero(div_by_zero)
    );

    localparam int NV = 11;
    localparam logic [31:0] VA [NV] = '{
        32'h40C00000, 32'h3F800000, 32'hC1000000, 32'h3F800000, 32'h40000000,
        32'h41200000, 32'h40E00000, 32'h3F800000, 32'h40A00000, 32'h3F800000,
        32'h4B000000};
    localparam logic [31:0] VB [NV] = '{
        32'h40000000, 32'h40400000, 32'h3F000000, 32'hC0800000, 32'h40400000,
        32'h40800000, 32'h40E00000, 32'h40E00000, 32'h40400000, 32'h40A00000,
        32'h3F800000};
    localparam logic [31:0] VQ [NV] = '{
        32'h40400000, 32'h3EAAAAAB, 32'hC1800000, 32'hBE800000, 32'h3F2AAAAB,
        32'h40200000, 32'h3F800000, 32'h3E124925, 32'h3FD55555, 32'h3E4CCCCD,
        32'h4B000000};

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        op_a = a; op_b = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: outputs during and right after reset
        chk({busy, done, div_by_zero, result} == '0, "R8 in reset", {busy, done, div_by_zero, result[28:0]}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, div_by_zero, result} == '0, "R8 after reset", {busy, done, div_by_zero, result[28:0]}, 32'd0);

        // table walk: R1 sign, R2 exponent, R3 fraction
        for (int i = 0; i < NV; i++) begin
            run(VA[i], VB[i]);
            chk(result[31] == VQ[i][31], "R1 sign", {31'd0, result[31]}, {31'd0, VQ[i][31]});
            chk(result[30:23] == VQ[i][30:23], "R2 exponent", {24'd0, result[30:23]}, {24'd0, VQ[i][30:23]});
            chk(result[22:0] == VQ[i][22:0], "R3 fraction", result, VQ[i]);
            chk(div_by_zero == 1'b0, "R3 no flag", {31'd0, div_by_zero}, 32'd0);
        end

        // R6: latency, busy and pulse width
        run(32'h40C00000, 32'h40000000);
        chk(lat == 28, "R6 latency", lat, 28);
        chk(busy == 1'b0, "R6 busy low at done", {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", {31'd0, done}, 32'd0);
        // R9: hold after done
        repeat (5) @(negedge clk);
        chk(result == 32'h40400000, "R9 result held", result, 32'h40400000);

        // R4: zero dividend
        run(32'h80000000, 32'h40000000);
        chk(result == 32'h80000000 && !div_by_zero, "R4 neg zero", result, 32'h80000000);
        run(32'h00000000, 32'hC0000000);
        chk(result == 32'h80000000 && !div_by_zero, "R4 signed zero R1", result, 32'h80000000);

        // R5: zero divisor
        run(32'h3F800000, 32'h80000000);
        chk(result == 32'hFF800000 && div_by_zero, "R5 neg inf", result, 32'hFF800000);
        run(32'h00000000, 32'h00000000);
        chk(result == 32'h7F800000 && div_by_zero, "R5 zero over zero", result, 32'h7F800000);
        // R9: flag from previous result held until the next done
        chk(div_by_zero == 1'b1, "R9 flag held", {31'd0, div_by_zero}, 32'd1);
        run(32'h41200000, 32'h40800000);
        chk(result == 32'h40200000 && !div_by_zero, "R5 flag clears", {div_by_zero, result[30:0]}, 32'h40200000);

        // R7: start while busy is ignored
        @(negedge clk);
        op_a = 32'h3F800000; op_b = 32'h40400000; start = 1'b1;
        @(negedge clk);
        start = 1'b0; lat = 0;
        repeat (5) begin @(negedge clk); lat++; end
        op_a = 32'h40C00000; op_b = 32'h40000000; start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        chk(lat == 28, "R7 timing unchanged", lat, 28);
        chk(result == 32'h3EAAAAAB, "R7 first operands kept", result, 32'h3EAAAAAB);
        @(negedge clk);
        chk(busy == 1'b0, "R7 no second run", {31'd0, busy}, 32'd0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule